// File: doc/BRIEF.md
# Histogram Mean Exposure Controller

This block sits beside an image sensor's pixel port and keeps the picture brightness near a programmed level. It measures every second frame, computes the average 8-bit intensity of that frame, and runs a proportional-integral-derivative step that moves two sensor settings: the frame delay, which sets how long each row is exposed, and the analogue gain. After each step it presents the new values as staging values with a one-cycle commit strobe. A register-bus master outside the block uses the strobe to write them to the sensor, and the sensor applies them one frame later.

The frame delay is held between two limits. Which pair of limits applies depends on a light mode. In good light a short window of delays is allowed. When the delay is driven into the top of that window, the block changes to low light, where a longer window applies. It returns to good light once the delay has dropped below a hysteresis point. Gain moves by a single step, and only when the control law asks for a delay beyond the active window.

Top module: `expo_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `frame_delay` equals DLY_INIT (100), `gain` is 0, `update` is 0 and `low_light` is 0.
- R2: Only the first frame after reset is measured, then every second frame after it; a frame is the span from one `frame_start` pulse to the next `frame_end` pulse. A frame that is not measured causes no `update` pulse and changes no output.
- R3: The measured mean is floor(sum of the pixel values with `pix_valid` high / number of such pixels). A measured frame that contains no valid pixels causes no `update` pulse and changes no output.
- R4: With e = target - mean, the integral is i' = clamp(i + e, -I_LIM, I_LIM) with I_LIM = 64, the derivative term is d = e - e_prev, and u = (KP*e + KI*i' + KD*d) arithmetically shifted right by SHIFT bits (floor). The defaults are KP=4, KI=1, KD=2, SHIFT=2. The requested delay is s = delay + u.
- R5: The new frame delay is s clamped to the window of the current mode: [16, 200] in good light and [64, 800] in low light.
- R6: The mode changes from good to low light when the new delay equals 200. It changes from low light back to good when the new delay is below 100. The new mode appears in the same cycle as the new delay. `low_light` is 1 in low light.
- R7: Gain rises by 1 when s is above the active window and falls by 1 when s is below it. It is otherwise unchanged. The result is then clamped to [`gain_min`, `gain_max`].
- R8: `update` is a single-cycle pulse that appears a fixed number of cycles after the end of a measured frame. `frame_delay`, `gain` and `low_light` change only in a cycle where `update` is 1.

Top module ports, in order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Pixel qualifier |
| pix_data | input | PIX_W | Pixel intensity |
| frame_start | input | 1 | One-cycle pulse before a frame's first pixel |
| frame_end | input | 1 | One-cycle pulse after a frame's last pixel |
| target_mean | input | PIX_W | Desired mean intensity |
| gain_min | input | GAIN_W | Lowest allowed gain |
| gain_max | input | GAIN_W | Highest allowed gain |
| frame_delay | output | DLY_W | Staged frame delay |
| gain | output | GAIN_W | Staged analogue gain |
| update | output | 1 | Commit strobe for the staged values |
| low_light | output | 1 | Current light mode, 1 = low light |

## Verification
A wrong accumulator or divider result shows up as a wrong delay at the next commit, about 30 cycles after the end of the measured frame. A wrong integral or previous-error value can leave that first commit unaffected and only shift the delay one measured frame later. Each delay is therefore compared against a model that is carried across long runs of dark, bright and mid-level frames. A wrong parity in the alternate-frame selector shows up within two frames, as a strobe after a frame that should be skipped or a missing strobe after one that should be measured. A wrong mode bit shows up as a delay clamped at the wrong window edge.

// File: rtl/expo_pkg.sv
// Shared types for the exposure controller.
package expo_pkg;
    typedef enum logic {LM_GOOD = 1'b0, LM_LOW = 1'b1} light_mode_t;
endpackage

// File: rtl/frame_mean.sv
// frame_mean: sums the pixels of every second frame and divides the sum by
// the pixel count with a serial restoring divider, which delivers one
// quotient bit per cycle. The sum is the first moment of the frame's
// intensity histogram, so no bin storage is needed.
// Assumes: a frame holds fewer than 2**CNT_W pixels, and a measured frame
// never ends while the divider is still busy. The skipped frame between two
// measured frames guarantees this.
module frame_mean #(
    parameter int PIX_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             frame_start,
    input  logic             frame_end,
    output logic             mean_valid,
    output logic [PIX_W-1:0] mean
);
    localparam int SUM_W = CNT_W + PIX_W;
    localparam int IT_W  = $clog2(SUM_W + 1);

    logic             take, active, busy;
    logic [SUM_W-1:0] sum, dvd;
    logic [CNT_W-1:0] cnt, dvs;
    logic [CNT_W:0]   rem;
    logic [CNT_W+1:0] rem_sh;
    logic             fits;
    logic [IT_W-1:0]  iter;

    // Next partial remainder and quotient bit of the divider.
    always_comb begin
        rem_sh = {rem, dvd[SUM_W-1]};
        fits   = rem_sh >= {2'b00, dvs};
    end

    // Frame parity, and the sum and count of the frame being measured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take   <= 1'b1;
            active <= 1'b0;
            sum    <= '0;
            cnt    <= '0;
        end else if (frame_start) begin
            active <= take;
            take   <= ~take;
            sum    <= '0;
            cnt    <= '0;
        end else if (frame_end) begin
            active <= 1'b0;
        end else if (active && pix_valid) begin
            sum <= sum + SUM_W'(pix_data);
            cnt <= cnt + 1'b1;
        end
    end

    // Serial divider, started at the end of a non-empty measured frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            iter       <= '0;
            dvd        <= '0;
            dvs        <= '0;
            rem        <= '0;
            mean       <= '0;
            mean_valid <= 1'b0;
        end else begin
            mean_valid <= 1'b0;
            if (frame_end && active && cnt != '0) begin
                busy <= 1'b1;
                iter <= IT_W'(SUM_W);
                dvd  <= sum;
                dvs  <= cnt;
                rem  <= '0;
            end else if (busy) begin
                rem  <= fits ? (CNT_W+1)'(rem_sh - {2'b00, dvs}) : rem_sh[CNT_W:0];
                dvd  <= dvd << 1;
                mean <= {mean[PIX_W-2:0], fits};
                iter <= iter - 1'b1;
                if (iter == IT_W'(1)) begin
                    busy       <= 1'b0;
                    mean_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pid_step.sv
// pid_step: combinational control law. From the current mean and the loop
// state it forms the next delay, gain, mode, integral and error.
// Assumes: the window limits fit in DLY_W bits and CW covers every term.
module pid_step
    import expo_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int DLY_W    = 10,
    parameter int GAIN_W   = 4,
    parameter int CW       = 18,
    parameter int GOOD_MIN = 16,
    parameter int GOOD_MAX = 200,
    parameter int LOW_MIN  = 64,
    parameter int LOW_MAX  = 800,
    parameter int HYST     = 100,
    parameter int KP       = 4,
    parameter int KI       = 1,
    parameter int KD       = 2,
    parameter int SHIFT    = 2,
    parameter int I_LIM    = 64
) (
    input  logic [PIX_W-1:0]     target,
    input  logic [PIX_W-1:0]     mean,
    input  logic [DLY_W-1:0]     dly,
    input  logic [GAIN_W-1:0]    gain,
    input  logic [GAIN_W-1:0]    gain_min,
    input  logic [GAIN_W-1:0]    gain_max,
    input  light_mode_t          mode,
    input  logic signed [CW-1:0] integ,
    input  logic signed [CW-1:0] prev_err,
    output logic [DLY_W-1:0]     dly_n,
    output logic [GAIN_W-1:0]    gain_n,
    output light_mode_t          mode_n,
    output logic signed [CW-1:0] integ_n,
    output logic signed [CW-1:0] err
);
    localparam int GS = GAIN_W + 2;
    localparam logic signed [CW-1:0] ILIM_S = CW'(I_LIM);

    logic signed [CW-1:0] i_sum, acc, u, s, lo, hi;
    logic                 over, under;
    logic signed [GS-1:0] g_s, g_step, gmin_s, gmax_s, g_cl;

    // Error, anti-windup integral, control output and requested delay.
    always_comb begin
        err     = signed'(CW'(target)) - signed'(CW'(mean));
        i_sum   = integ + err;
        integ_n = (i_sum > ILIM_S) ? ILIM_S : ((i_sum < -ILIM_S) ? -ILIM_S : i_sum);
        acc     = CW'(err * KP + integ_n * KI + (err - prev_err) * KD);
        u       = acc >>> SHIFT;
        s       = signed'(CW'(dly)) + u;
    end

    // Window of the current mode, delay clamp and saturation flags.
    always_comb begin
        lo    = (mode == LM_LOW) ? CW'(LOW_MIN) : CW'(GOOD_MIN);
        hi    = (mode == LM_LOW) ? CW'(LOW_MAX) : CW'(GOOD_MAX);
        over  = s > hi;
        under = s < lo;
        dly_n = over ? DLY_W'(hi) : (under ? DLY_W'(lo) : DLY_W'(s));
    end

    // One gain step when the delay saturates, bounded by the configuration.
    always_comb begin
        g_s    = signed'(GS'(gain));
        gmin_s = signed'(GS'(gain_min));
        gmax_s = signed'(GS'(gain_max));
        g_step = over ? (g_s + GS'(1)) : (under ? (g_s - GS'(1)) : g_s);
        g_cl   = (g_step > gmax_s) ? gmax_s : ((g_step < gmin_s) ? gmin_s : g_step);
        gain_n = GAIN_W'(g_cl);
    end

    // Light mode change with hysteresis.
    always_comb begin
        mode_n = mode;
        if (mode == LM_GOOD && dly_n == DLY_W'(GOOD_MAX))
            mode_n = LM_LOW;
        else if (mode == LM_LOW && dly_n < DLY_W'(HYST))
            mode_n = LM_GOOD;
    end
endmodule

// File: rtl/expo_ctrl.sv
// expo_ctrl: exposure controller top. It measures the mean of alternate
// frames, runs one control step per measurement, and holds the staged delay
// and gain, presenting them with a one-cycle commit strobe.
// Assumes: the frame markers are single-cycle pulses and the pixels lie
// between them.
module expo_ctrl
    import expo_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int CNT_W    = 16,
    parameter int DLY_W    = 10,
    parameter int GAIN_W   = 4,
    parameter int DLY_INIT = 100,
    parameter int GOOD_MIN = 16,
    parameter int GOOD_MAX = 200,
    parameter int LOW_MIN  = 64,
    parameter int LOW_MAX  = 800,
    parameter int HYST     = 100,
    parameter int KP       = 4,
    parameter int KI       = 1,
    parameter int KD       = 2,
    parameter int SHIFT    = 2,
    parameter int I_LIM    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic [PIX_W-1:0]  target_mean,
    input  logic [GAIN_W-1:0] gain_min,
    input  logic [GAIN_W-1:0] gain_max,
    output logic [DLY_W-1:0]  frame_delay,
    output logic [GAIN_W-1:0] gain,
    output logic              update,
    output logic              low_light
);
    localparam int CW = DLY_W + PIX_W;

    logic                 mean_valid;
    logic [PIX_W-1:0]     mean;
    light_mode_t          mode, mode_n;
    logic signed [CW-1:0] integ, prev_err, integ_n, err;
    logic [DLY_W-1:0]     dly_n;
    logic [GAIN_W-1:0]    gain_n;

    frame_mean #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_mean (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .frame_start(frame_start),
        .frame_end  (frame_end),
        .mean_valid (mean_valid),
        .mean       (mean)
    );

    pid_step #(
        .PIX_W(PIX_W), .DLY_W(DLY_W), .GAIN_W(GAIN_W), .CW(CW),
        .GOOD_MIN(GOOD_MIN), .GOOD_MAX(GOOD_MAX), .LOW_MIN(LOW_MIN),
        .LOW_MAX(LOW_MAX), .HYST(HYST), .KP(KP), .KI(KI), .KD(KD),
        .SHIFT(SHIFT), .I_LIM(I_LIM)
    ) u_pid (
        .target  (target_mean),
        .mean    (mean),
        .dly     (frame_delay),
        .gain    (gain),
        .gain_min(gain_min),
        .gain_max(gain_max),
        .mode    (mode),
        .integ   (integ),
        .prev_err(prev_err),
        .dly_n   (dly_n),
        .gain_n  (gain_n),
        .mode_n  (mode_n),
        .integ_n (integ_n),
        .err     (err)
    );

    // Staging registers and loop state, loaded once per measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_delay <= DLY_W'(DLY_INIT);
            gain        <= '0;
            mode        <= LM_GOOD;
            integ       <= '0;
            prev_err    <= '0;
            update      <= 1'b0;
        end else begin
            update <= mean_valid;
            if (mean_valid) begin
                frame_delay <= dly_n;
                gain        <= gain_n;
                mode        <= mode_n;
                integ       <= integ_n;
                prev_err    <= err;
            end
        end
    end

    // Mode flag at the port.
    always_comb low_light = (mode == LM_LOW);
endmodule

// File: rtl/expo_ctrl_chk.sv
// expo_ctrl_chk: temporal properties of the exposure controller's ports.
// Assumes: it is bound into expo_ctrl with matching window parameters.
module expo_ctrl_chk #(
    parameter int DLY_W    = 10,
    parameter int GAIN_W   = 4,
    parameter int GOOD_MIN = 16,
    parameter int GOOD_MAX = 200,
    parameter int LOW_MIN  = 64,
    parameter int LOW_MAX  = 800,
    parameter int HYST     = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DLY_W-1:0]  frame_delay,
    input logic [GAIN_W-1:0] gain,
    input logic              update,
    input logic              low_light
);
    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> !update);

    p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !update |-> ($stable(frame_delay) && $stable(gain) && $stable(low_light)));

    p_good_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !low_light |-> (frame_delay >= DLY_W'(GOOD_MIN) && frame_delay <= DLY_W'(GOOD_MAX)));

    p_low_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        low_light |-> (frame_delay >= DLY_W'(LOW_MIN) && frame_delay <= DLY_W'(LOW_MAX)));

    p_enter_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_light) |-> (frame_delay == DLY_W'(GOOD_MAX)));

    p_leave_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(low_light) |-> (frame_delay < DLY_W'(HYST)));

    p_gain_inside_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (update && !low_light && !$past(low_light) &&
         frame_delay > DLY_W'(GOOD_MIN) && frame_delay < DLY_W'(GOOD_MAX))
        |-> (gain == $past(gain)));
endmodule

bind expo_ctrl expo_ctrl_chk #(
    .DLY_W(DLY_W), .GAIN_W(GAIN_W), .GOOD_MIN(GOOD_MIN), .GOOD_MAX(GOOD_MAX),
    .LOW_MIN(LOW_MIN), .LOW_MAX(LOW_MAX), .HYST(HYST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_delay(frame_delay),
    .gain       (gain),
    .update     (update),
    .low_light  (low_light)
);

// File: tb/expo_ctrl_tb.sv
// expo_ctrl_tb: drives runs of dark, bright, empty and mid-level frames. It
// models the control law arithmetically and compares every commit with it.
module expo_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_valid = 1'b0;
    logic [7:0] pix_data = '0;
    logic       frame_start = 1'b0;
    logic       frame_end = 1'b0;
    logic [7:0] target_mean = 8'd128;
    logic [3:0] gain_min = 4'd0;
    logic [3:0] gain_max = 4'd3;
    logic [9:0] frame_delay;
    logic [3:0] gain;
    logic       update;
    logic       low_light;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int frm_idx = 0;
    int m_dly = 100, m_gain = 0, m_low = 0, m_int = 0, m_prev = 0;

    expo_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
        .frame_start(frame_start), .frame_end(frame_end),
        .target_mean(target_mean), .gain_min(gain_min), .gain_max(gain_max),
        .frame_delay(frame_delay), .gain(gain), .update(update),
        .low_light(low_light)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL R8 watchdog: actual %0d cycles, expected under 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Independent model of one control step.
    task automatic model_step(input int mean);
        int e, i, u, s, lo, hi, g;
        e = int'(target_mean) - mean;
        i = m_int + e;
        if (i > 64) i = 64;
        if (i < -64) i = -64;
        u = (4 * e + i + 2 * (e - m_prev)) >>> 2;
        s = m_dly + u;
        lo = m_low ? 64 : 16;
        hi = m_low ? 800 : 200;
        g = m_gain;
        if (s > hi) begin m_dly = hi; g = g + 1; end
        else if (s < lo) begin m_dly = lo; g = g - 1; end
        else m_dly = s;
        if (g > int'(gain_max)) g = int'(gain_max);
        if (g < int'(gain_min)) g = int'(gain_min);
        m_gain = g;
        if (!m_low && m_dly == 200) m_low = 1;
        else if (m_low && m_dly < 100) m_low = 0;
        m_int = i;
        m_prev = e;
    endtask

    // One frame; pixel k is (base + k*step) mod 256.
    task automatic run_frame(input int n, input int base, input int step, input string tag);
        bit meas, seen;
        int sum, odly, ogain, olow;
        meas = (frm_idx % 2 == 0);
        frm_idx++;
        sum = 0;
        odly = int'(frame_delay); ogain = int'(gain); olow = int'(low_light);
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            pix_valid = 1'b1;
            pix_data = 8'((base + k * step) & 255);
            sum += (base + k * step) & 255;
            @(negedge clk);
        end
        pix_valid = 1'b0;
        frame_end = 1'b1;
        @(negedge clk) frame_end = 1'b0;
        if (meas && n > 0) begin
            seen = 1'b0;
            for (int w = 0; w < 100 && !seen; w++) begin
                @(negedge clk);
                if (update) seen = 1'b1;
            end
            chk(seen, "R2 strobe after measured frame", int'(seen), 1);
            model_step(sum / n);
            chk(int'(frame_delay) == m_dly, {tag, " R3/R4/R5 delay"}, int'(frame_delay), m_dly);
            chk(int'(gain) == m_gain, {tag, " R7 gain"}, int'(gain), m_gain);
            chk(int'(low_light) == m_low, {tag, " R6 mode"}, int'(low_light), m_low);
            @(negedge clk);
            chk(!update, "R8 strobe lasts one cycle", int'(update), 0);
        end else begin
            seen = 1'b0;
            for (int w = 0; w < 60; w++) begin
                @(negedge clk);
                if (update) seen = 1'b1;
            end
            chk(!seen && int'(frame_delay) == odly && int'(gain) == ogain &&
                int'(low_light) == olow,
                meas ? "R3 empty frame ignored" : "R2 skipped frame ignored",
                int'(frame_delay), odly);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(frame_delay == 10'd100, "R1 reset delay", int'(frame_delay), 100);
        chk(gain == 4'd0, "R1 reset gain", int'(gain), 0);
        chk(!update, "R1 reset strobe", int'(update), 0);
        chk(!low_light, "R1 reset mode", int'(low_light), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(frame_delay == 10'd100 && !update, "R1 first cycle after reset", int'(frame_delay), 100);
        // Dark frames climb through both windows and saturate the gain;
        // each skipped frame is bright and must leave no trace.
        for (int f = 0; f < 12; f++) begin
            run_frame(20, 0, 1, "dark");
            run_frame(15, 240, 1, "skip");
        end
        // A measured frame with no valid pixels.
        run_frame(0, 0, 0, "empty");
        run_frame(10, 50, 1, "skip");
        // Bright frames drive the delay down, back to good light and gain 0.
        for (int f = 0; f < 16; f++) begin
            run_frame(15, 240, 1, "bright");
            run_frame(20, 0, 1, "skip");
        end
        // Mid-level frames whose means need truncating division.
        for (int f = 0; f < 10; f++) begin
            run_frame(6 + f, 100 + 3 * f, 5, "floor");
            run_frame(3, 7, 1, "skip");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule